// File: doc/BRIEF.md
# Line-Sensor Digitizer Serial Port

This block is the digital side of a line-sensor digitizer. It has one serial wire whose direction is set by a mode input. With the mode input low, the port takes in 8-bit control words on rising edges of the serial clock. A rising edge on the commit strobe then copies the word's payload into one of two registers: a channel selector or a 6-bit amplifier gain code. The first two bits of the word choose the register.

With the mode input high, the port sends out 8-bit pixel results, most significant bit first. Each word starts at the falling edge of the pixel-sample strobe. A result enters through a parallel input when the converter stand-in strobes it. It then passes through a holding stage and a storage stage before it reaches the output shifter. The word for a pixel therefore appears two sample cycles after that pixel was sampled.

All external strobes are sampled in one system clock domain, and their edges are found by comparison with the previous sample. A synchronous reset stands in for the power-on pulse. It selects the sensor path and the lowest gain.

Top module: `pixSerialPort`

## Requirements
- R1: After reset, `muxSel` is 0 (sensor path), `gainCode` is 0 (gain -2), and `dataOut` is 0.
- R2: `dataOe` is 1 exactly while `modeSel` is 1. While `modeSel` is 0 the output driver is released and `dataIn` is the serial input.
- R3: When `modeSel` is 0, each rising edge of `sclkIn` shifts `dataIn` into an 8-bit input word, first bit at the top. If more than 8 bits arrive, the last 8 are kept. The top two bits are the address: 10 selects the channel register, 01 selects the gain register, and 00 or 11 changes nothing. The low six bits are the payload.
- R4: A rising edge of `loadIn` while `modeSel` is 0 commits the word only if at least 8 bits have been shifted in since the last such edge. Every such edge clears the bit count, whether or not it commits.
- R5: When `modeSel` is 1, `loadIn` edges commit nothing, and `sclkIn` edges neither shift the input word nor advance its bit count.
- R6: A gain write copies payload bits [5:0] unchanged into `gainCode`. Code c stands for gain -(2 + c/8), so code 63 is -9.875.
- R7: A channel write takes payload bits [1:0]. The values are 00 for the sensor path, 01 for auxiliary 1 and 10 for auxiliary 2. The value 11 is reserved and leaves `muxSel` unchanged.
- R8: On the system clock edge that sees a falling edge of `vidSampIn`, the output shifter loads a new word. Its D7 is on `dataOut` right after that edge.
- R9: When `modeSel` is 1, each rising edge of `sclkIn` shifts the output word one place, presenting D6 through D0 in turn. After D0 the output is 0. Without a serial-clock rising edge or a sample-strobe fall, `dataOut` holds its value.
- R10: A result strobed by `convStrobe` after sample-strobe fall k appears on `dataOut` from fall k+2. If there are several strobes between two falls, the last one is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset, stands in for power-on |
| modeSel | input | 1 | 1: pixel readout, 0: control-word input |
| sclkIn | input | 1 | Serial clock, sampled, active on its rising edge |
| loadIn | input | 1 | Commit strobe, active on its rising edge |
| vidSampIn | input | 1 | Pixel-sample strobe, frames readout on its falling edge |
| dataIn | input | 1 | Serial wire as seen by the input buffer |
| dataOut | output | 1 | Serial wire output value |
| dataOe | output | 1 | Output driver enable for the serial wire |
| convResult | input | 8 | Parallel pixel result from the converter stand-in |
| convStrobe | input | 1 | One-cycle strobe capturing `convResult` |
| muxSel | output | 2 | Channel selector register |
| gainCode | output | 6 | Amplifier gain code register |

## Verification
The bench uses the default build: 8-bit words, a 6-bit gain code, a 2-bit channel field and zero fill after D0. With these sizes every gain code can be written, and every channel value, reserved value and no-op address can be tried. Twenty pixels of readout are checked bit by bit, including the bit past D0. The bench's own model of the hold, storage and shifter stages shows the two-cycle latency, and the case where the last of several strobes wins. It also checks short words, words longer than 8 bits, and commits tried in readout mode, all through the register outputs.

// File: rtl/pixPortPkg.sv
package pixPortPkg;

  typedef struct packed {
    logic shiftIn;
    logic shiftOut;
    logic vidFall;
    logic convCapture;
    logic commitMux;
    logic commitGain;
  } portStrobe_t;

  localparam logic [1:0] ADDR_MUX     = 2'b10;
  localparam logic [1:0] ADDR_GAIN    = 2'b01;
  localparam logic [1:0] MUX_RESERVED = 2'b11;

endpackage

// File: rtl/pixPortCtrl.sv
module pixPortCtrl
  import pixPortPkg::*;
#(
  parameter int WORD_W = 8,
  parameter int MUX_W  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             modeSel,
  input  logic             sclkIn,
  input  logic             loadIn,
  input  logic             vidSampIn,
  input  logic             convStrobe,
  input  logic [1:0]       addrBits,
  input  logic [MUX_W-1:0] muxPayload,
  output portStrobe_t      strobes
);

  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(WORD_W);

  logic sclkQ, loadQ, vidQ;
  logic sclkRise, loadRise, vidFall;
  logic [CNT_W-1:0] bitCnt;
  logic wordFull, loadAccept;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclkQ <= 1'b0;
      loadQ <= 1'b0;
      vidQ  <= 1'b0;
    end else begin
      sclkQ <= sclkIn;
      loadQ <= loadIn;
      vidQ  <= vidSampIn;
    end
  end

  assign sclkRise = sclkIn & ~sclkQ;
  assign loadRise = loadIn & ~loadQ;
  assign vidFall  = ~vidSampIn & vidQ;

  assign loadAccept = loadRise & ~modeSel;
  assign wordFull   = (bitCnt == FULL_CNT);

  always_ff @(posedge clk) begin
    if (rst) begin
      bitCnt <= '0;
    end else if (loadAccept) begin
      bitCnt <= '0;
    end else if (sclkRise && !modeSel && !wordFull) begin
      bitCnt <= bitCnt + 1'b1;
    end
  end

  always_comb begin
    strobes             = '0;
    strobes.shiftIn     = sclkRise & ~modeSel;
    strobes.shiftOut    = sclkRise & modeSel;
    strobes.vidFall     = vidFall;
    strobes.convCapture = convStrobe;
    strobes.commitGain  = loadAccept & wordFull & (addrBits == ADDR_GAIN);
    strobes.commitMux   = loadAccept & wordFull & (addrBits == ADDR_MUX)
                        & (muxPayload != MUX_W'(MUX_RESERVED));
  end

endmodule

// File: rtl/pixPortDatapath.sv
module pixPortDatapath
  import pixPortPkg::*;
#(
  parameter int WORD_W    = 8,
  parameter int GAIN_W    = 6,
  parameter int MUX_W     = 2,
  parameter bit TAIL_ZERO = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  portStrobe_t       strobes,
  input  logic              dataIn,
  input  logic [WORD_W-1:0] convResult,
  output logic [1:0]        addrBits,
  output logic [MUX_W-1:0]  muxPayload,
  output logic              dataOut,
  output logic [MUX_W-1:0]  muxSel,
  output logic [GAIN_W-1:0] gainCode
);

  localparam int ADDR_W = WORD_W - GAIN_W;

  logic [WORD_W-1:0] inWord;
  logic [WORD_W-1:0] holdReg;
  logic [WORD_W-1:0] storeReg;
  logic [WORD_W-1:0] outShift;
  logic [GAIN_W-1:0] payload;
  logic              tailBit;

  assign payload    = inWord[GAIN_W-1:0];
  assign addrBits   = inWord[WORD_W-1 -: ADDR_W];
  assign muxPayload = payload[MUX_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      inWord <= '0;
    end else if (strobes.shiftIn) begin
      inWord <= {inWord[WORD_W-2:0], dataIn};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      muxSel   <= '0;
      gainCode <= '0;
    end else begin
      if (strobes.commitMux)  muxSel   <= muxPayload;
      if (strobes.commitGain) gainCode <= payload;
    end
  end

  generate
    if (TAIL_ZERO) begin : g_zeroTail
      assign tailBit = 1'b0;
    end else begin : g_holdTail
      assign tailBit = outShift[0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      holdReg  <= '0;
      storeReg <= '0;
      outShift <= '0;
    end else begin
      if (strobes.vidFall) begin
        storeReg <= holdReg;
        outShift <= storeReg;
      end else if (strobes.shiftOut) begin
        outShift <= {outShift[WORD_W-2:0], tailBit};
      end
      if (strobes.convCapture) holdReg <= convResult;
    end
  end

  assign dataOut = outShift[WORD_W-1];

endmodule

// File: rtl/pixSerialPort.sv
module pixSerialPort
  import pixPortPkg::*;
#(
  parameter int WORD_W    = 8,
  parameter int GAIN_W    = 6,
  parameter int MUX_W     = 2,
  parameter bit TAIL_ZERO = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              modeSel,
  input  logic              sclkIn,
  input  logic              loadIn,
  input  logic              vidSampIn,
  input  logic              dataIn,
  output logic              dataOut,
  output logic              dataOe,
  input  logic [WORD_W-1:0] convResult,
  input  logic              convStrobe,
  output logic [MUX_W-1:0]  muxSel,
  output logic [GAIN_W-1:0] gainCode
);

  portStrobe_t      strobes;
  logic [1:0]       addrBits;
  logic [MUX_W-1:0] muxPayload;

  pixPortCtrl #(.WORD_W(WORD_W), .MUX_W(MUX_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .modeSel    (modeSel),
    .sclkIn     (sclkIn),
    .loadIn     (loadIn),
    .vidSampIn  (vidSampIn),
    .convStrobe (convStrobe),
    .addrBits   (addrBits),
    .muxPayload (muxPayload),
    .strobes    (strobes)
  );

  pixPortDatapath #(
    .WORD_W(WORD_W), .GAIN_W(GAIN_W), .MUX_W(MUX_W), .TAIL_ZERO(TAIL_ZERO)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .strobes    (strobes),
    .dataIn     (dataIn),
    .convResult (convResult),
    .addrBits   (addrBits),
    .muxPayload (muxPayload),
    .dataOut    (dataOut),
    .muxSel     (muxSel),
    .gainCode   (gainCode)
  );

  assign dataOe = modeSel;

endmodule

// File: rtl/pixSerialPortChk.sv
module pixSerialPortChk #(
  parameter int GAIN_W = 6,
  parameter int MUX_W  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              modeSel,
  input logic              sclkIn,
  input logic              loadIn,
  input logic              vidSampIn,
  input logic              dataOut,
  input logic [MUX_W-1:0]  muxSel,
  input logic [GAIN_W-1:0] gainCode
);

  logic sclkQ, loadQ, vidQ;

  always_ff @(posedge clk) begin
    sclkQ <= sclkIn;
    loadQ <= loadIn;
    vidQ  <= vidSampIn;
  end

  // R1: reset leaves the defaults on the outputs
  a_r1_reset_defaults: assert property (@(posedge clk)
    rst |=> (muxSel == '0) && (gainCode == '0) && (dataOut == 1'b0));

  // R3: the registers move only on a load edge in input mode
  a_r3_regs_only_on_load: assert property (@(posedge clk) disable iff (rst)
    !(loadIn && !loadQ && !modeSel) |=> $stable(gainCode) && $stable(muxSel));

  // R5: load edges in readout mode are ignored
  a_r5_load_ignored_out_mode: assert property (@(posedge clk) disable iff (rst)
    (loadIn && !loadQ && modeSel) |=> $stable(gainCode) && $stable(muxSel));

  // R9: the serial output moves only on a shift or a frame start
  a_r9_out_holds: assert property (@(posedge clk) disable iff (rst)
    (!(sclkIn && !sclkQ && modeSel) && !(!vidSampIn && vidQ)) |=> $stable(dataOut));

  // R7: the reserved channel value is never reached
  always @(posedge clk) begin
    if (!rst) begin
      a_r7_no_reserved_mux: assert (muxSel != MUX_W'(2'b11));
    end
  end

endmodule

bind pixSerialPort pixSerialPortChk #(.GAIN_W(GAIN_W), .MUX_W(MUX_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .modeSel   (modeSel),
  .sclkIn    (sclkIn),
  .loadIn    (loadIn),
  .vidSampIn (vidSampIn),
  .dataOut   (dataOut),
  .muxSel    (muxSel),
  .gainCode  (gainCode)
);

// File: tb/tb_pixSerialPort.sv
`timescale 1ns/1ps
module tb_pixSerialPort;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       modeSel = 1'b0;
  logic       sclkIn = 1'b0;
  logic       loadIn = 1'b0;
  logic       vidSampIn = 1'b0;
  logic       dataIn = 1'b0;
  logic       dataOut, dataOe;
  logic [7:0] convResult = 8'h00;
  logic       convStrobe = 1'b0;
  logic [1:0] muxSel;
  logic [5:0] gainCode;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pixSerialPort dut (
    .clk(clk), .rst(rst), .modeSel(modeSel), .sclkIn(sclkIn), .loadIn(loadIn),
    .vidSampIn(vidSampIn), .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe),
    .convResult(convResult), .convStrobe(convStrobe), .muxSel(muxSel), .gainCode(gainCode)
  );

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sclkPulse();
    sclkIn = 1'b1; step(2);
    sclkIn = 1'b0; step(2);
  endtask

  task automatic loadPulse();
    loadIn = 1'b1; step(2);
    loadIn = 1'b0; step(2);
  endtask

  task automatic shiftBits(input logic [15:0] bits, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      dataIn = bits[i];
      sclkPulse();
    end
  endtask

  task automatic writeWord(input logic [7:0] w);
    modeSel = 1'b0; step(1);
    shiftBits({8'h00, w}, 8);
    loadPulse();
  endtask

  function automatic logic [7:0] pixVal(input int p);
    return 8'((p * 37 + 11) ^ (p << 4));
  endfunction

  initial begin
    #500000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] holdM, storeM, shiftM;
    int expMux;

    step(3);
    rst = 1'b0;
    step(1);
    // R1 reset defaults
    chk("R1 muxSel", int'(muxSel), 0);
    chk("R1 gainCode", int'(gainCode), 0);
    chk("R1 dataOut", int'(dataOut), 0);
    // R2 driver follows mode
    chk("R2 dataOe in input mode", int'(dataOe), 0);

    // R6 sweep every gain code, channel must not move
    for (int g = 0; g < 64; g++) begin
      writeWord({2'b01, 6'(g)});
      chk("R6 gain write", int'(gainCode), g);
      chk("R6 mux untouched", int'(muxSel), 0);
    end

    // R7 channel values, reserved leaves it alone
    writeWord({2'b10, 4'h0, 2'b01});
    chk("R7 aux1", int'(muxSel), 1);
    writeWord({2'b10, 4'hF, 2'b10});
    chk("R7 aux2", int'(muxSel), 2);
    writeWord({2'b10, 4'h0, 2'b11});
    chk("R7 reserved keeps", int'(muxSel), 2);
    chk("R7 gain untouched", int'(gainCode), 63);
    writeWord({2'b10, 4'h0, 2'b00});
    chk("R7 sensor path", int'(muxSel), 0);
    expMux = 0;

    // R3 no-op addresses
    writeWord({2'b00, 6'h15});
    chk("R3 noop 00 gain", int'(gainCode), 63);
    chk("R3 noop 00 mux", int'(muxSel), expMux);
    writeWord({2'b11, 6'h16});
    chk("R3 noop 11 gain", int'(gainCode), 63);
    chk("R3 noop 11 mux", int'(muxSel), expMux);

    // R3 over-length word keeps the last eight bits
    modeSel = 1'b0; step(1);
    shiftBits({6'h0, 2'b11, 2'b01, 6'h15}, 10);
    loadPulse();
    chk("R3 last eight bits kept", int'(gainCode), 8'h15);

    // R4 short word is ignored and clears the count
    shiftBits({10'h0, 2'b01, 4'h3}, 6);
    loadPulse();
    chk("R4 short word ignored", int'(gainCode), 8'h15);
    shiftBits({8'h00, 2'b01, 6'h2A}, 8);
    loadPulse();
    chk("R4 full word after clear", int'(gainCode), 8'h2A);

    // R5 serial clocks in readout mode do not count
    shiftBits({10'h0, 2'b01, 4'h7}, 6);
    modeSel = 1'b1; step(1);
    chk("R2 dataOe in readout mode", int'(dataOe), 1);
    sclkPulse(); sclkPulse();
    modeSel = 1'b0; step(1);
    loadPulse();
    chk("R5 readout clocks not counted", int'(gainCode), 8'h2A);

    // R5 load in readout mode commits nothing; R4 count survives
    shiftBits({8'h00, 2'b01, 6'h07}, 8);
    modeSel = 1'b1; step(1);
    loadPulse();
    chk("R5 load ignored in readout", int'(gainCode), 8'h2A);
    modeSel = 1'b0; step(1);
    loadPulse();
    chk("R4 commit after returning", int'(gainCode), 8'h07);

    // R8 R9 R10 pixel stream with bench model of the pipeline
    holdM = 8'h00; storeM = 8'h00; shiftM = 8'h00;
    modeSel = 1'b1; step(1);
    for (int p = 0; p < 20; p++) begin
      vidSampIn = 1'b1; step(3);
      vidSampIn = 1'b0; step(1);
      shiftM = storeM; storeM = holdM;
      chk("R8 D7 at frame start", int'(dataOut), int'(shiftM[7]));
      if (p % 5 == 3) begin
        convResult = 8'hA5; convStrobe = 1'b1; step(1);
        convStrobe = 1'b0; step(1);
      end
      convResult = pixVal(p); convStrobe = 1'b1; step(1);
      convStrobe = 1'b0; step(1);
      holdM = pixVal(p);
      for (int b = 6; b >= 0; b--) begin
        sclkPulse();
        chk("R9 R10 shifted bit", int'(dataOut), int'(shiftM[b]));
      end
      sclkPulse();
      chk("R9 zero after D0", int'(dataOut), 0);
      step(1);
      chk("R9 output holds", int'(dataOut), 0);
    end

    // R5 readout activity leaves configuration untouched
    chk("R5 gain after readout", int'(gainCode), 8'h07);
    chk("R5 mux after readout", int'(muxSel), expMux);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule